// File: doc/BRIEF.md
# Sparse Pixel Cluster Finder

This block sits behind a row of per-column flash converters. Each time `row_valid` is high, the block takes one complete row of 5-bit pixel samples, one sample per column. It slides a two-by-two summing window over each adjacent pair of rows. Wherever the window total is strictly above a single programmable threshold, the block marks the seven-by-seven patch of pixels around that window for readout. Patches from nearby hits merge. Marked pixels leave the block one at a time through a small output queue, and each word carries its row, its column and its sample. Unmarked pixels produce no output.

The input rate cannot be paused. The block therefore never stalls its input. When the serialiser falls behind, or the queue is full, words are discarded and a sticky overflow flag records the loss. The design is sized for low occupancy: a row reaches the serialiser four rows after it enters, and a row normally sends only a few words.

Top module: `pixel_cluster_finder`

## Requirements
- R1: A row is taken on each clock edge with `row_valid` high. Column c occupies bits [5c+4:5c] of `row_pix`. Rows are numbered 0, 1, 2… from the first row after reset.
- R2: A window with top row k and left column j covers rows k and k+1 and columns j and j+1. It is a hit when the sum of its four samples is strictly greater than `threshold`, using the threshold present when row k+1 is taken.
- R3: A hit at window (k, j) marks rows k-3..k+3 and columns j-3..j+3. The marking is clipped to columns 0..NCOL-1 and to rows at or after row 0, and it never wraps around.
- R4: Only marked pixels are output. A pixel marked by several overlapping hits is output exactly once.
- R5: An output word is {row[7:0], column[6:0], sample[4:0]}: row in bits [19:12], column in [11:5] and sample in [4:0].
- R6: Words leave in ascending row order. Within a row they leave in ascending column order.
- R7: The words of row p enter the queue one per clock. The first of them is written on the edge after the edge that takes row p+4, and `out_valid` rises after that edge.
- R8: A word that arrives while the queue holds FIFO_DEPTH words is dropped. `overflow` is then set, and it stays set until reset. Words already queued are delivered unchanged, and the input is never stalled.
- R9: Suppose a new row reaches the serialiser while marked pixels of the previous row are still unsent. The remaining pixels, apart from the one sent in that cycle, are dropped and `overflow` is set.
- R10: After reset, `out_valid` and `overflow` are low.
- R11: A word is removed from the queue on each clock edge with `out_valid` and `out_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_valid | input | 1 | A new row is present on `row_pix` |
| row_pix | input | NCOL*5 | One row of 5-bit samples, column 0 in the low bits |
| threshold | input | 7 | Global window-sum threshold |
| out_ready | input | 1 | Consumer takes the head word |
| out_valid | output | 1 | Queue holds at least one word |
| out_word | output | 20 | Head word {row, column, sample} |
| overflow | output | 1 | Sticky word-loss flag |

## Verification
The words of row p become due when row p+4 is taken. The first word is written one edge after that, and the rest follow one per clock. The bench therefore builds the expected words of row p when it presents row p+4, and it matches the delivered words in order rather than at fixed cycles. Once, with an empty queue, it samples `out_valid` half a clock after the taking edge, where it must still be low, and again one clock later, where it must be high. Between rows it leaves more cycles than there are columns, so that the serialiser can finish a full row before the next one arrives. The two overflow paths are checked after stimulus built to trigger them: a held-off consumer for the full queue, and back-to-back rows for the serialiser.

// File: rtl/cfind_pkg.sv
package cfind_pkg;
  // half-width of the readout patch around a window's top-left pixel
  localparam int REACH = 3;
  // rows between a row's arrival and its hand-over to the serialiser
  localparam int LAG = REACH + 1;
  // extra bits for a four-sample sum
  localparam int SUM_GROW = 2;
endpackage

// File: rtl/clf_detect.sv
module clf_detect
  import cfind_pkg::*;
#(
  parameter int NCOL  = 125,
  parameter int PIX_W = 5,
  localparam int THR_W = PIX_W + SUM_GROW
) (
  input  logic [NCOL*PIX_W-1:0] cur_pix,
  input  logic [NCOL*PIX_W-1:0] prev_pix,
  input  logic [THR_W-1:0]      thr,
  input  logic                  kern_en,
  output logic [NCOL-1:0]       spread
);
  logic [NCOL-2:0] hit;

  for (genvar j = 0; j < NCOL - 1; j++) begin : g_kern
    logic [THR_W-1:0] ksum;
    assign ksum = THR_W'(cur_pix[j*PIX_W +: PIX_W])
                + THR_W'(cur_pix[(j+1)*PIX_W +: PIX_W])
                + THR_W'(prev_pix[j*PIX_W +: PIX_W])
                + THR_W'(prev_pix[(j+1)*PIX_W +: PIX_W]);
    assign hit[j] = kern_en && (ksum > thr);
  end

  // horizontal spreading, clipped at both array edges
  for (genvar c = 0; c < NCOL; c++) begin : g_spread
    localparam int LO = (c - REACH < 0) ? 0 : c - REACH;
    localparam int HI = (c + REACH > NCOL - 2) ? NCOL - 2 : c + REACH;
    assign spread[c] = |hit[HI:LO];
  end
endmodule

// File: rtl/clf_window.sv
module clf_window
  import cfind_pkg::*;
#(
  parameter int NCOL  = 125,
  parameter int PIX_W = 5,
  parameter int ROW_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  row_valid,
  input  logic [NCOL*PIX_W-1:0] row_pix,
  input  logic [NCOL-1:0]       new_spread,
  output logic [NCOL*PIX_W-1:0] prev_pix,
  output logic                  kern_en,
  output logic                  load,
  output logic [NCOL*PIX_W-1:0] load_pix,
  output logic [NCOL-1:0]       load_mask,
  output logic [ROW_W-1:0]      load_row
);
  localparam int ROWBITS = NCOL * PIX_W;
  localparam int HDEPTH  = 2 * REACH;
  localparam int FILL_W  = $clog2(LAG + 1);

  logic [ROWBITS-1:0] pix_q [LAG];
  logic [ROWBITS-1:0] pix_d [LAG];
  logic [NCOL-1:0]    hs_q  [HDEPTH];
  logic [NCOL-1:0]    hs_d  [HDEPTH];
  logic [FILL_W-1:0]  fill_q, fill_d;
  logic [ROW_W-1:0]   cnt_q, cnt_d;
  logic               primed;
  logic [NCOL-1:0]    old_or;

  assign primed = (fill_q == FILL_W'(LAG));

  always_comb begin
    pix_d[0] = row_pix;
    for (int i = 1; i < LAG; i++) pix_d[i] = pix_q[i-1];
    hs_d[0] = new_spread;
    for (int i = 1; i < HDEPTH; i++) hs_d[i] = hs_q[i-1];
    fill_d = primed ? fill_q : fill_q + FILL_W'(1);
    cnt_d  = cnt_q + ROW_W'(1);
    old_or = '0;
    for (int i = 0; i < HDEPTH; i++) old_or = old_or | hs_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAG; i++) pix_q[i] <= '0;
      for (int i = 0; i < HDEPTH; i++) hs_q[i] <= '0;
      fill_q <= '0;
      cnt_q  <= '0;
    end else if (row_valid) begin
      for (int i = 0; i < LAG; i++) pix_q[i] <= pix_d[i];
      for (int i = 0; i < HDEPTH; i++) hs_q[i] <= hs_d[i];
      fill_q <= fill_d;
      cnt_q  <= cnt_d;
    end
  end

  assign prev_pix  = pix_q[0];
  assign kern_en   = (fill_q != '0);
  assign load      = row_valid && primed;
  assign load_pix  = pix_q[LAG-1];
  assign load_mask = new_spread | old_or;
  assign load_row  = cnt_q - ROW_W'(LAG);

  // R3
  top_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !primed) |=> (fill_q == $past(fill_q) + FILL_W'(1)));
endmodule

// File: rtl/clf_scan.sv
module clf_scan #(
  parameter int NCOL  = 125,
  parameter int PIX_W = 5,
  parameter int ROW_W = 8,
  localparam int COL_W  = $clog2(NCOL),
  localparam int WORD_W = ROW_W + COL_W + PIX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NCOL*PIX_W-1:0] load_pix,
  input  logic [NCOL-1:0]       load_mask,
  input  logic [ROW_W-1:0]      load_row,
  output logic                  emit,
  output logic [WORD_W-1:0]     emit_word,
  output logic                  drop
);
  logic [NCOL-1:0]       mask_q, mask_d, onehot, rest;
  logic [NCOL*PIX_W-1:0] pix_q;
  logic [ROW_W-1:0]      row_q;
  logic [COL_W-1:0]      sel;

  always_comb begin
    sel = '0;
    for (int i = NCOL - 1; i >= 0; i--) begin
      if (mask_q[i]) sel = COL_W'(i);
    end
    onehot = NCOL'(1) << sel;
    rest   = mask_q & ~onehot;
    mask_d = load ? load_mask : rest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pix_q  <= '0;
      row_q  <= '0;
    end else begin
      mask_q <= mask_d;
      if (load) begin
        pix_q <= load_pix;
        row_q <= load_row;
      end
    end
  end

  assign emit      = |mask_q;
  assign drop      = load && (|rest);
  assign emit_word = {row_q, sel, pix_q[int'(sel)*PIX_W +: PIX_W]};

  // R4
  one_per_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && emit) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
  // R6
  col_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && emit) |=> (!emit || (sel > $past(sel))));
endmodule

// File: rtl/clf_fifo.sv
module clf_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic             valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic             full, wr_acc, rd_acc;

  assign full   = (cnt_q == (AW+1)'(DEPTH));
  assign valid  = (cnt_q != '0);
  assign wr_acc = wr_en && !full;
  assign rd_acc = rd_en && valid;
  assign drop   = wr_en && full;

  always_comb begin
    wp_d  = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    rp_d  = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    cnt_d = cnt_q + (AW+1)'(wr_acc) - (AW+1)'(rd_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_acc) wp_q <= wp_d;
      if (rd_acc) rp_q <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];

  // R8
  stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);
  // R11
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && valid && !wr_en) |=> (cnt_q == $past(cnt_q) - (AW+1)'(1)));
endmodule

// File: rtl/pixel_cluster_finder.sv
module pixel_cluster_finder
  import cfind_pkg::*;
#(
  parameter int NCOL       = 125,
  parameter int PIX_W      = 5,
  parameter int ROW_W      = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int COL_W  = $clog2(NCOL),
  localparam int THR_W  = PIX_W + SUM_GROW,
  localparam int WORD_W = ROW_W + COL_W + PIX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  row_valid,
  input  logic [NCOL*PIX_W-1:0] row_pix,
  input  logic [THR_W-1:0]      threshold,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [WORD_W-1:0]     out_word,
  output logic                  overflow
);
  logic [1:0]            rst_sync;
  logic                  rst_q;
  logic [NCOL*PIX_W-1:0] prev_pix, load_pix;
  logic [NCOL-1:0]       spread, load_mask;
  logic [ROW_W-1:0]      load_row;
  logic                  kern_en, load;
  logic                  emit, scan_drop, fifo_drop;
  logic [WORD_W-1:0]     emit_word;
  logic                  ovf_q, ovf_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  clf_detect #(.NCOL(NCOL), .PIX_W(PIX_W)) i_detect (
    .cur_pix(row_pix), .prev_pix(prev_pix), .thr(threshold),
    .kern_en(kern_en), .spread(spread)
  );

  clf_window #(.NCOL(NCOL), .PIX_W(PIX_W), .ROW_W(ROW_W)) i_window (
    .clk(clk), .rst_n(rst_q), .row_valid(row_valid), .row_pix(row_pix),
    .new_spread(spread), .prev_pix(prev_pix), .kern_en(kern_en),
    .load(load), .load_pix(load_pix), .load_mask(load_mask), .load_row(load_row)
  );

  clf_scan #(.NCOL(NCOL), .PIX_W(PIX_W), .ROW_W(ROW_W)) i_scan (
    .clk(clk), .rst_n(rst_q), .load(load), .load_pix(load_pix),
    .load_mask(load_mask), .load_row(load_row),
    .emit(emit), .emit_word(emit_word), .drop(scan_drop)
  );

  clf_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_q), .wr_en(emit), .wr_data(emit_word),
    .rd_en(out_ready), .valid(out_valid), .rd_data(out_word), .drop(fifo_drop)
  );

  always_comb ovf_d = ovf_q | scan_drop | fifo_drop;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end
  assign overflow = ovf_q;

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    overflow |=> overflow);
  // R9
  ovf_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (scan_drop || fifo_drop) |=> overflow);
endmodule

// File: tb/test_pixel_cluster_finder.sv
module test_pixel_cluster_finder;
  localparam int NCOL = 125;
  localparam int PW   = 5;
  localparam int RW   = 8;
  localparam int CW   = 7;
  localparam int FD   = 16;
  localparam int WW   = RW + CW + PW;
  localparam int GAP  = NCOL + 6;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               row_valid = 1'b0;
  logic [NCOL*PW-1:0] row_pix = '0;
  logic [PW+1:0]      threshold = 7'd40;
  logic               out_ready = 1'b1;
  logic               out_valid;
  logic [WW-1:0]      out_word;
  logic               overflow;

  always #2 clk = ~clk;

  pixel_cluster_finder i_pixel_cluster_finder (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_pix(row_pix),
    .threshold(threshold), .out_ready(out_ready), .out_valid(out_valid),
    .out_word(out_word), .overflow(overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int nrows = 0;
  int rx_cnt = 0;
  bit ignore_rx = 1'b0;
  int pix_m [256][NCOL];
  bit hit_m [256][NCOL-1];
  logic [WW-1:0] exp_q [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit flag_at(input int p, input int c);
    for (int k = p - 3; k <= p + 3; k++) begin
      if (k >= 0 && k <= nrows - 2) begin
        for (int j = c - 3; j <= c + 3; j++) begin
          if (j >= 0 && j <= NCOL - 2 && hit_m[k][j]) return 1'b1;
        end
      end
    end
    return 1'b0;
  endfunction

  function automatic logic [NCOL*PW-1:0] rand_row();
    logic [NCOL*PW-1:0] r;
    for (int c = 0; c < NCOL; c++) begin
      if ($urandom_range(0, 999) < 990) r[c*PW +: PW] = PW'($urandom_range(0, 3));
      else                              r[c*PW +: PW] = PW'($urandom_range(12, 31));
    end
    return r;
  endfunction

  function automatic logic [NCOL*PW-1:0] fill_row(input int v);
    logic [NCOL*PW-1:0] r;
    for (int c = 0; c < NCOL; c++) r[c*PW +: PW] = PW'(v);
    return r;
  endfunction

  // model: R1 R2 R3 row accounting, expected words built when row p+4 arrives
  task automatic present(input logic [NCOL*PW-1:0] d, input int gap, input bit lat_chk);
    int n;
    @(negedge clk);
    row_pix = d;
    row_valid = 1'b1;
    n = nrows;
    for (int c = 0; c < NCOL; c++) pix_m[n][c] = int'(d[c*PW +: PW]);
    if (n >= 1) begin
      for (int j = 0; j < NCOL - 1; j++)
        hit_m[n-1][j] = (pix_m[n-1][j] + pix_m[n-1][j+1] + pix_m[n][j] + pix_m[n][j+1])
                        > int'(threshold);
    end
    nrows++;
    if (n >= 4) begin
      for (int c = 0; c < NCOL; c++)
        if (flag_at(n - 4, c))
          exp_q.push_back({RW'(n - 4), CW'(c), PW'(pix_m[n-4][c])});
    end
    @(negedge clk);
    row_valid = 1'b0;
    if (lat_chk) check(out_valid == 1'b0, "R7 out_valid half a clock after taking edge", out_valid, 0);
    @(negedge clk);
    if (lat_chk) check(out_valid == 1'b1, "R7 out_valid one clock later", out_valid, 1);
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nrows = 0;
    exp_q.delete();
  endtask

  // collector: R4 R5 R6 R11 stream comparison
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (out_valid && out_ready && !ignore_rx) begin
        rx_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected word", out_word, 0);
        end else begin
          check(out_word == exp_q[0], "R5 R6 word content and order", out_word, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NCOL*PW-1:0] r;
    int unsigned seed;
    seed = $urandom(32'h1d2c3b4a);
    do_reset();
    // R10
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    check(overflow == 1'b0, "R10 overflow after reset", overflow, 0);

    // directed: window at row 0 column 0 and at the right edge (R3 clipping)
    threshold = 7'd40;
    r = '0;
    r[0 +: PW] = 5'd31; r[1*PW +: PW] = 5'd31;
    r[123*PW +: PW] = 5'd31; r[124*PW +: PW] = 5'd31;
    present(r, GAP, 1'b0);
    for (int i = 1; i < 4; i++) present('0, 0, 1'b0);
    check(out_valid == 1'b0, "R7 nothing before row 4", out_valid, 0);
    present('0, GAP, 1'b1);
    // overlapping patches from neighbouring hits (R4 merging)
    r = '0;
    r[60*PW +: PW] = 5'd31; r[61*PW +: PW] = 5'd20;
    present(r, GAP, 1'b0);
    r = '0;
    r[62*PW +: PW] = 5'd31;
    present(r, GAP, 1'b0);
    for (int i = 0; i < 3; i++) present('0, GAP, 1'b0);

    // constrained random rows, threshold changes (R2)
    for (int i = 0; i < 130; i++) begin
      if (i % 20 == 0) threshold = 7'($urandom_range(30, 70));
      present(rand_row(), GAP, 1'b0);
    end
    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected words delivered", exp_q.size(), 0);
    check(overflow == 1'b0, "R8 no overflow in normal traffic", overflow, 0);

    // queue full: consumer held off (R8)
    out_ready = 1'b0;
    rx_cnt = 0;
    threshold = 7'd40;
    present(fill_row(31), GAP, 1'b0);
    for (int i = 0; i < 4; i++) present('0, GAP, 1'b0);
    check(overflow == 1'b1, "R8 overflow on full queue", overflow, 1);
    out_ready = 1'b1;
    repeat (40) @(negedge clk);
    check(rx_cnt == FD, "R8 queued words kept", rx_cnt, FD);
    check(out_valid == 1'b0, "R11 queue drained", out_valid, 0);
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

    // reset, then rows back to back (R9)
    ignore_rx = 1'b1;
    do_reset();
    check(overflow == 1'b0, "R10 overflow cleared", overflow, 0);
    check(out_valid == 1'b0, "R10 queue empty", out_valid, 0);
    for (int i = 0; i < 8; i++) present(fill_row(31), 0, 1'b0);
    @(negedge clk);
    check(overflow == 1'b1, "R9 overflow on serialiser reload", overflow, 1);
    repeat (200) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule